// File: doc/BRIEF.md
# Multi-Policy Dynamic Bus Arbiter

This block decides which of N requesters owns a shared bus. Each requester raises its bit of a request vector and holds it while it wants the bus. The arbiter answers with a registered grant vector that has at most one bit set. The owner gives the bus back in one of two ways: it pulses the release input, or it drops its request.

The priority scheme is picked at run time by a mode input. There are five schemes:
- fixed-length time slices handed round in index order;
- a polling pointer that walks the requester indices;
- least-recently-granted first;
- arrival order;
- rotating priority counted from the previous owner.

Each scheme keeps its own history (slice counter, poll pointer, grant-age ranking, arrival queue), and that history is updated in every mode. A switch of scheme therefore starts from a consistent state. A new mode value is only taken up while no grant is out.

Top module: `arb_multi`

## Requirements
- R1: At most one bit of `gnt_o` is ever set, and `gnt_o` is all zero during reset and in the first cycle after it.
- R2: From the idle state a grant is only given to a requester whose request was high at that clock edge. When the owner pulses `release_i` or drops its request, `gnt_o` is all zero after the next edge, and the arbiter picks again from idle.
- R3: In every mode except time-slice, the grant stays unchanged while the owner keeps requesting and does not release.
- R4: Time-slice (mode value 0): after an owner has held the bus for SLICE cycles, the grant moves directly to the first requesting index after the owner, in circular ascending order. The owner keeps the bus if it is the only requester. The new holder starts a full slice.
- R5: Polling (mode value 1): while idle, the pointer advances by one index per clock (wrapping from N-1 to 0) as long as the pointed requester is not requesting. It grants the pointed requester when that requester is requesting. After any grant the pointer is set to the index after the new owner. The pointer is 0 after reset.
- R6: Least recently used (mode value 2): from idle, the grant goes to the requester whose last grant lies furthest in the past. Never-granted requesters count as older than any granted one, and among those a lower index counts as older.
- R7: Arrival order (mode value 3): a requester joins the queue in the cycle its request is high while it is neither queued, owner, nor being granted. Requesters joining in the same cycle are ordered by ascending index. A queued requester that drops its request leaves the queue. From idle, the earliest queued requester that is still requesting is granted.
- R8: Rotating (mode value 4, and the unused values 5 to 7): from idle, the grant goes to the first requesting index after the previous owner, in circular ascending order. The previous owner is N-1 after reset.
- R9: A new value on `mode_i` has no effect while a grant is out. The mode in force is taken from `mode_i` only in idle cycles.
- R10: In time-slice mode, the choice from idle follows the same circular rule as R8, starting after the previous owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Priority scheme select (0 slice, 1 poll, 2 LRU, 3 arrival order, 4..7 rotating) |
| req_i | input | N | One request bit per requester, held while the bus is wanted |
| release_i | input | 1 | Pulse from the current owner giving the bus back |
| gnt_o | output | N | Registered one-hot-or-zero grant |

## Verification
The hardest situation to reach is in arrival-order mode. Several requesters join in the same cycle while an earlier queued one withdraws and the owner releases, so the queue positions must close up and open up in one step. A second hard case is a slice that expires while the owner is the only requester left.

Directed sequences build these cases by hand. They raise several requests on one edge, drop one queued request at a time, and hold a lone owner across several slices. Long runs driven by a pseudo-random generator then flip requests, releases and modes, including mode changes while the bus is owned. A timestamp-based reference model predicts the grant in every cycle.

// File: rtl/arb_pol_pkg.sv
package arb_pol_pkg;

  typedef enum logic [2:0] {
    POL_SLICE = 3'd0,
    POL_POLL  = 3'd1,
    POL_LRU   = 3'd2,
    POL_FCFS  = 3'd3,
    POL_ROT   = 3'd4
  } policy_e;

  // Unused codes fall back to rotating priority.
  function automatic policy_e decode_mode(logic [2:0] v);
    if (v > 3'd4) return POL_ROT;
    return policy_e'(v);
  endfunction

endpackage

// File: rtl/arb_lru_rank.sv
module arb_lru_rank #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          grant_ev_i,
  input  logic [IW-1:0] grant_idx_i,
  output logic [N-1:0]  win_o
);

  // Higher rank means older last use.
  logic [IW-1:0] rank_q [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      win_o[i] = req_i[i];
      for (int j = 0; j < N; j++)
        if (j != i && req_i[j] && rank_q[j] > rank_q[i]) win_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IW'(N-1-i);
    end else if (grant_ev_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == grant_idx_i)             rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[grant_idx_i]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  assert_lru_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_o));

  assert_lru_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ev_i |=> rank_q[$past(grant_idx_i)] == '0);

endmodule

// File: rtl/arb_fcfs_order.sv
module arb_fcfs_order #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] owner_i,
  input  logic [N-1:0] nxt_i,
  output logic [N-1:0] win_o
);

  logic [N-1:0]  in_q;
  logic [IW-1:0] pos_q [N];
  logic [IW-1:0] pos_d [N];
  logic [N-1:0]  leave, arrive;

  assign leave  = in_q & (~req_i | nxt_i);
  assign arrive = req_i & ~in_q & ~owner_i & ~nxt_i;

  // Earliest queued requester that still requests.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      win_o[i] = in_q[i] & req_i[i];
      for (int j = 0; j < N; j++)
        if (in_q[j] && req_i[j] && pos_q[j] < pos_q[i]) win_o[i] = 1'b0;
    end
  end

  always_comb begin
    int surv;
    surv = 0;
    for (int i = 0; i < N; i++) if (in_q[i] && !leave[i]) surv++;
    for (int i = 0; i < N; i++) begin
      int shift;
      shift = 0;
      pos_d[i] = pos_q[i];
      if (in_q[i] && !leave[i]) begin
        for (int j = 0; j < N; j++) if (leave[j] && pos_q[j] < pos_q[i]) shift++;
        pos_d[i] = pos_q[i] - IW'(shift);
      end else if (arrive[i]) begin
        for (int j = 0; j < i; j++) if (arrive[j]) shift++;
        pos_d[i] = IW'(surv + shift);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q <= '0;
      for (int i = 0; i < N; i++) pos_q[i] <= '0;
    end else begin
      in_q <= (in_q & ~leave) | arrive;
      for (int i = 0; i < N; i++) pos_q[i] <= pos_d[i];
    end
  end

  assert_fcfs_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_o));

  assert_fcfs_owner_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q & owner_i) == '0);

endmodule

// File: rtl/arb_multi.sv
module arb_multi
  import arb_pol_pkg::*;
#(
  parameter int N     = 4,
  parameter int SLICE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode_i,
  input  logic [N-1:0] req_i,
  input  logic         release_i,
  output logic [N-1:0] gnt_o
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(SLICE + 1);

  logic [N-1:0]  gnt_q, nxt_gnt, lru_win, fcfs_win;
  logic [IW-1:0] last_q, ptr_q, own_idx, win_idx;
  logic [CW-1:0] cnt_q;
  policy_e       mode_q, mode_now;
  logic          busy, end_b, slice_exp, poll_step, new_grant;

  function automatic logic [IW-1:0] to_idx(logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (v[i]) r = IW'(i);
    return r;
  endfunction

  function automatic logic [IW-1:0] wrap_inc(logic [IW-1:0] v);
    return (v == IW'(N-1)) ? '0 : v + 1'b1;
  endfunction

  // First requester strictly after base, circularly; base itself is last.
  function automatic logic [N-1:0] pick_after(logic [N-1:0] r, logic [IW-1:0] base);
    logic [N-1:0] res;
    res = '0;
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = (int'(base) + k) % N;
      if (r[idx]) begin
        res = '0;
        res[idx] = 1'b1;
      end
    end
    return res;
  endfunction

  assign busy      = |gnt_q;
  assign own_idx   = to_idx(gnt_q);
  assign mode_now  = busy ? mode_q : decode_mode(mode_i);
  assign end_b     = busy && (release_i || !req_i[own_idx]);
  assign slice_exp = busy && !end_b && mode_now == POL_SLICE && cnt_q == CW'(SLICE-1);

  always_comb begin
    nxt_gnt   = gnt_q;
    poll_step = 1'b0;
    if (!busy) begin
      case (mode_now)
        POL_POLL: begin
          if (req_i[ptr_q]) begin
            nxt_gnt = '0;
            nxt_gnt[ptr_q] = 1'b1;
          end else begin
            poll_step = 1'b1;
          end
        end
        POL_LRU:  nxt_gnt = lru_win;
        POL_FCFS: nxt_gnt = fcfs_win;
        default:  nxt_gnt = pick_after(req_i, last_q);
      endcase
    end else if (end_b) begin
      nxt_gnt = '0;
    end else if (slice_exp) begin
      nxt_gnt = pick_after(req_i, own_idx);
    end
  end

  assign new_grant = (nxt_gnt != '0) && (!busy || slice_exp);
  assign win_idx   = to_idx(nxt_gnt);

  arb_lru_rank #(.N(N), .IW(IW)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .grant_ev_i (new_grant),
    .grant_idx_i(win_idx),
    .win_o      (lru_win)
  );

  arb_fcfs_order #(.N(N), .IW(IW)) u_fcfs (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .owner_i(gnt_q),
    .nxt_i  (nxt_gnt),
    .win_o  (fcfs_win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= IW'(N-1);
      ptr_q  <= '0;
      cnt_q  <= '0;
      mode_q <= POL_SLICE;
    end else begin
      gnt_q  <= nxt_gnt;
      mode_q <= mode_now;
      if (new_grant) begin
        last_q <= win_idx;
        ptr_q  <= wrap_inc(win_idx);
        cnt_q  <= '0;
      end else begin
        if (poll_step) ptr_q <= wrap_inc(ptr_q);
        if (busy && !end_b && mode_now == POL_SLICE) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign gnt_o = gnt_q;

  assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  assert_idle_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (gnt_o & ~$past(req_i)) == '0);

  assert_release_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    end_b |=> gnt_o == '0);

  assert_hold_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q != POL_SLICE && !end_b) |=> $stable(gnt_o));

  assert_slice_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_exp && (req_i & ~gnt_o) != '0) |=> gnt_o != $past(gnt_o));

  assert_poll_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_step |=> gnt_o == '0);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_b) |=> mode_q == $past(mode_q));

endmodule

// File: tb/sim_arb_multi.sv
module sim_arb_multi;
  localparam int N = 4;
  localparam int SLICE = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode_i = '0;
  logic [N-1:0] req_i = '0;
  logic         release_i = 1'b0;
  wire  [N-1:0] gnt_o;

  arb_multi #(.N(N), .SLICE(SLICE)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .req_i(req_i), .release_i(release_i), .gnt_o(gnt_o)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  // Reference model: grant history kept as timestamps.
  int m_own = -1, m_mode = 0, m_cnt = 0, m_last = N-1, m_ptr = 0, m_cyc = 0;
  int m_use[N];
  bit m_qd[N];
  int m_at[N];
  logic [15:0] lf = 16'hACE1;

  task automatic check(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: gnt actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int dec(logic [2:0] v);
    return (v > 3'd4) ? 4 : int'(v);
  endfunction

  function automatic int after(logic [N-1:0] r, int base);
    for (int k = 1; k <= N; k++) if (r[(base + k) % N]) return (base + k) % N;
    return -1;
  endfunction

  function automatic void lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endfunction

  // Driver: apply inputs, advance the model, push the expected grant.
  task automatic step(logic [2:0] md, logic [N-1:0] rq, logic rl);
    int m, nxt;
    bit busy, fin, exp_s, ev;
    string tag;
    logic [N-1:0] ev_vec;
    @(negedge clk);
    mode_i = md; req_i = rq; release_i = rl;
    busy  = (m_own >= 0);
    m     = busy ? m_mode : dec(md);
    fin   = busy && (rl || !rq[m_own]);
    exp_s = busy && !fin && m == 0 && m_cnt == SLICE-1;
    nxt   = m_own;
    if (!busy) begin
      case (m)
        1: nxt = rq[m_ptr] ? m_ptr : -1;
        2: begin
          nxt = -1;
          for (int i = 0; i < N; i++)
            if (rq[i] && (nxt < 0 || m_use[i] < m_use[nxt])) nxt = i;
        end
        3: begin
          nxt = -1;
          for (int i = 0; i < N; i++)
            if (m_qd[i] && rq[i] && (nxt < 0 || m_at[i] < m_at[nxt])) nxt = i;
        end
        default: nxt = after(rq, m_last);
      endcase
    end else if (fin) nxt = -1;
    else if (exp_s) nxt = after(rq, m_own);

    if (busy && fin) tag = "R2";
    else if (busy && dec(md) != m_mode) tag = "R9";
    else if (busy && m != 0) tag = "R3";
    else if (busy) tag = "R4";
    else case (m)
      0: tag = "R10";
      1: tag = "R5";
      2: tag = "R6";
      3: tag = "R7";
      default: tag = "R8";
    endcase

    ev = (nxt >= 0) && (!busy || exp_s);
    for (int i = 0; i < N; i++) begin
      if (m_qd[i] && (!rq[i] || nxt == i)) m_qd[i] = 0;
      else if (!m_qd[i] && rq[i] && m_own != i && nxt != i) begin
        m_qd[i] = 1;
        m_at[i] = m_cyc;
      end
    end
    if (!busy && m == 1 && nxt < 0) m_ptr = (m_ptr + 1) % N;
    if (ev) begin
      m_use[nxt] = m_cyc;
      m_last = nxt;
      m_ptr = (nxt + 1) % N;
      m_cnt = 0;
    end else if (busy && !fin && m == 0) m_cnt++;
    m_own = nxt;
    m_mode = m;
    m_cyc++;
    ev_vec = '0;
    if (nxt >= 0) ev_vec[nxt] = 1'b1;
    exp_q.push_back(ev_vec);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare each cycle's grant with the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(gnt_o === e, t, gnt_o, e);
        check($onehot0(gnt_o), "R1", gnt_o, e);
      end
    end
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [N-1:0] rq;
    for (int i = 0; i < N; i++) begin
      m_use[i] = -(N - i);
      m_qd[i] = 0;
      m_at[i] = 0;
    end
    req_i = '1;
    repeat (3) @(negedge clk);
    check(gnt_o == '0, "R1", gnt_o, '0);   // reset state
    @(negedge clk);
    rst_n = 1'b1;

    // R8 rotating: all request, owner releases every other cycle
    for (int k = 0; k < 12; k++) step(3'd4, 4'b1111, k[0]);
    step(3'd6, 4'b0000, 1'b0);
    for (int k = 0; k < 8; k++) step(3'd7, 4'b1010, k[1] & k[0]);

    // R4 / R10 time slices, including a lone owner across several slices
    for (int k = 0; k < 20; k++) step(3'd0, 4'b1011, 1'b0);
    for (int k = 0; k < 12; k++) step(3'd0, 4'b0010, 1'b0);
    step(3'd0, 4'b0000, 1'b0);

    // R5 polling walk, hold, release, walk again
    for (int k = 0; k < 7; k++) step(3'd1, 4'b0100, 1'b0);
    step(3'd1, 4'b0100, 1'b1);
    for (int k = 0; k < 7; k++) step(3'd1, 4'b0001, 1'b0);
    step(3'd1, 4'b0000, 1'b0);

    // R6 least recently used
    for (int k = 0; k < 10; k++) step(3'd2, 4'b1111, (k % 3) == 2);
    for (int k = 0; k < 6; k++) step(3'd2, 4'b0110, k[0]);
    step(3'd2, 4'b0000, 1'b0);

    // R7 arrival order: single arrival, simultaneous arrivals, a withdrawal
    step(3'd3, 4'b0100, 1'b0);
    step(3'd3, 4'b0100, 1'b0);
    step(3'd3, 4'b1101, 1'b0);
    step(3'd3, 4'b1111, 1'b0);
    step(3'd3, 4'b1111, 1'b1);
    step(3'd3, 4'b1110, 1'b0);
    step(3'd3, 4'b1110, 1'b0);
    step(3'd3, 4'b0110, 1'b1);
    for (int k = 0; k < 8; k++) step(3'd3, 4'b1111, k[0]);
    step(3'd3, 4'b0000, 1'b0);

    // R9 mode change while owned has no effect until idle
    step(3'd2, 4'b1111, 1'b0);
    for (int k = 0; k < 7; k++) step(3'd0, 4'b1111, 1'b0);
    step(3'd0, 4'b1111, 1'b1);
    for (int k = 0; k < 9; k++) step(3'd0, 4'b1111, 1'b0);

    // Pseudo-random per mode, then with mode changes
    rq = '0;
    for (int md = 0; md < 5; md++) begin
      for (int k = 0; k < 800; k++) begin
        lfsr();
        if (lf[6:4] == 3'd0) rq = lf[3:0];
        step(3'(md), rq, lf[9:8] == 2'd0);
      end
    end
    for (int k = 0; k < 2000; k++) begin
      lfsr();
      if (lf[6:5] == 2'd0) rq = lf[3:0];
      step(lf[12:10], rq, lf[9:8] == 2'd0);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule